// File: doc/BRIEF.md
# Message Length and Checksum Checker

This block sits next to a CRC kernel and supervises messages. It does not compute any CRC. Each data write that the kernel accepts is reported on a strobe. The block counts that strobe down against a programmed message length. When the count goes from one to zero, the message has ended. The kernel result is then compared with a stored expected value, provided the check is enabled.

The length and expected-value registers are protected. To change one, software first writes a fixed key word to that register and then writes the real value. A write that skips the key is rejected and raises a configuration error.

Four sticky error flags record the outcomes: checksum mismatch, configuration error, length error and bus error. Each flag has its own interrupt enable, and the enabled flags share one interrupt line. A flag stays set until software writes a one to it. A write-only test register injects faults so that the error path can be exercised. An optional reload mode restarts the length count for back-to-back messages of the same size.

Top module: `msg_len_check`

## Requirements
- R1: After reset, `status_o`, `len_o`, `irq_o` and `rd_data_o` are all zero.
- R2: Address 1 (length) and address 2 (check value) load only from a write that directly follows a write of 0xFACECAFE to the same address. Any write to another address in between cancels the unlock.
- R3: A write to address 1 or 2 that is not unlocked and does not carry the key sets status bit 1 (configuration error). The target register keeps its value.
- R4: Each cycle with `in_wr_i` high and a nonzero length decrements `len_o` by one on that clock edge.
- R5: The end of a message is the input write that takes the length from 1 to 0. If CFG bit 0 (check enable) is set, `crc_res_i` is sampled in the following cycle and compared with the check value. A difference sets status bit 0 (mismatch) on that edge.
- R6: With CFG bit 1 (reload) set, the end-of-message write loads `len_o` with the last keyed length instead of zero.
- R7: An input write while the length is zero and reload is off sets status bit 2 (length error). The length stays zero.
- R8: A high `bus_err_i` sets status bit 3 (bus error) on the next edge.
- R9: Status flags are sticky. Writing to address 3 clears every flag whose data bit is one. A set event in the same cycle wins over the clear.
- R10: `irq_o` equals the OR of the status bits ANDed with their enables, delayed by one cycle. The enables are CFG bits 5..2, for status bits 3..0 in order.
- R11: A write to address 4 (test) injects faults. Data bit 0 forces the next checked comparison to report a mismatch. Data bits 1 and 2 each set status bit 1 at once.
- R12: `rd_data_o` returns, one cycle after `rd_addr_i`, the value at that address: 0 for CFG, 1 for the live length, 2 for the check value, 3 for status, 5 for the stored reload length. All other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | WR_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | WR_W | Registered read data |
| in_wr_i | input | 1 | Kernel accepted one input word |
| crc_res_i | input | DATA_W | Current kernel result |
| bus_err_i | input | 1 | Kernel saw an illegal access |
| len_o | output | LEN_W | Live remaining length |
| status_o | output | 4 | Sticky flags: bit 0 mismatch, bit 1 config, bit 2 length, bit 3 bus |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checker module watches four properties on every cycle:
- flags never drop without a clear write;
- the interrupt follows the enabled flags one cycle later;
- the length counts down by exactly one per input write above one;
- length, bus and rejected-write events always land in their flags.

The key sequence, the timing of the comparison after the final write, reload restoring the programmed count, the priority of a set over a same-cycle clear, and fault injection all need specific orderings of writes. Only the bench scenarios show these, and they are checked cycle by cycle against the bench's reference model.

// File: rtl/msg_chk_pkg.sv
package msg_chk_pkg;
  localparam logic [2:0] A_CFG = 3'd0;
  localparam logic [2:0] A_LEN = 3'd1;
  localparam logic [2:0] A_CHK = 3'd2;
  localparam logic [2:0] A_STS = 3'd3;
  localparam logic [2:0] A_TST = 3'd4;
  localparam logic [2:0] A_RLD = 3'd5;

  localparam int FLAG_N = 4;

  // CFG layout: [5:2] interrupt enables, [1] reload, [0] check enable
  typedef struct packed {
    logic [FLAG_N-1:0] ie;
    logic              reload;
    logic              chk_en;
  } cfg_t;

  // flag vector layout: [3] bus, [2] length, [1] config, [0] mismatch
  typedef struct packed {
    logic bus;
    logic len;
    logic cfg;
    logic mis;
  } flags_t;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
  import msg_chk_pkg::*;
#(
  parameter int               WR_W       = 32,
  parameter int               DATA_W     = 32,
  parameter logic [WR_W-1:0]  UNLOCK_KEY = WR_W'(32'hFACECAFE)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [WR_W-1:0]   wr_data_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] check_o,
  output logic              len_load_o,
  output logic              cfg_err_o,
  output logic [2:0]        test_o,
  output logic [FLAG_N-1:0] sts_clr_o
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t              cfg_q;
  logic [DATA_W-1:0] check_q;
  logic              unl_v_q;
  logic [2:0]        unl_a_q;

  logic prot, hit, key_wr, chk_load;

  // protected target addressed at all
  assign prot     = wr_en_i && (wr_addr_i == A_LEN || wr_addr_i == A_CHK);
  // second half of a keyed pair
  assign hit      = prot && unl_v_q && (unl_a_q == wr_addr_i);
  assign key_wr   = prot && !hit && (wr_data_i == UNLOCK_KEY);
  assign len_load_o = hit && (wr_addr_i == A_LEN);
  assign chk_load   = hit && (wr_addr_i == A_CHK);
  assign cfg_err_o  = prot && !hit && !key_wr;

  assign test_o    = (wr_en_i && wr_addr_i == A_TST) ? wr_data_i[2:0] : 3'b000;
  assign sts_clr_o = (wr_en_i && wr_addr_i == A_STS) ? wr_data_i[FLAG_N-1:0] : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q   <= '0;
      check_q <= '0;
      unl_v_q <= 1'b0;
      unl_a_q <= '0;
    end else if (wr_en_i) begin
      // any write other than a fresh key drops the unlock
      unl_v_q <= key_wr;
      if (key_wr) unl_a_q <= wr_addr_i;
      if (wr_addr_i == A_CFG) cfg_q <= cfg_t'(wr_data_i[CFG_W-1:0]);
      if (chk_load) check_q <= wr_data_i[DATA_W-1:0];
    end
  end

  assign cfg_o   = cfg_q;
  assign check_o = check_q;
endmodule

// File: rtl/mc_len_counter.sv
module mc_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             in_wr_i,
  input  logic             reload_en_i,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] rld_o,
  output logic             eom_o,
  output logic             len_err_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] len_q, rld_q;
  logic             eom_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      len_q <= '0;
      rld_q <= '0;
      eom_q <= 1'b0;
    end else begin
      eom_q <= 1'b0;
      if (load_i) begin
        len_q <= load_val_i;
        rld_q <= load_val_i;
      end else if (in_wr_i && len_q != '0) begin
        if (len_q == ONE) begin
          eom_q <= 1'b1;
          len_q <= reload_en_i ? rld_q : '0;
        end else begin
          len_q <= len_q - ONE;
        end
      end
    end
  end

  assign len_err_o = in_wr_i && !load_i && (len_q == '0) && !reload_en_i;
  assign len_o = len_q;
  assign rld_o = rld_q;
  assign eom_o = eom_q;
endmodule

// File: rtl/mc_status.sv
module mc_status
  import msg_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [FLAG_N-1:0] set_i,
  input  logic [FLAG_N-1:0] clr_i,
  input  logic [FLAG_N-1:0] ie_i,
  output logic [FLAG_N-1:0] flags_o,
  output logic              irq_o
);
  logic [FLAG_N-1:0] flags_q;
  logic              irq_q;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (rst_i) flags_q[i] <= 1'b0;
      else       flags_q[i] <= set_i[i] | (flags_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |(flags_q & ie_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/msg_len_check.sv
module msg_len_check
  import msg_chk_pkg::*;
#(
  parameter int WR_W   = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [WR_W-1:0]   wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [WR_W-1:0]   rd_data_o,
  input  logic              in_wr_i,
  input  logic [DATA_W-1:0] crc_res_i,
  input  logic              bus_err_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [3:0]        status_o,
  output logic              irq_o
);
  cfg_t              cfg;
  logic [DATA_W-1:0] check_val;
  logic              len_load, cfg_err, len_err, eom;
  logic [2:0]        test_pulse;
  logic [FLAG_N-1:0] sts_clr, sts_set, flags;
  logic [LEN_W-1:0]  len_live, len_rld;
  logic              force_q, consume, mis_evt;
  logic              reload_en;
  logic [FLAG_N-1:0] ie;
  logic [WR_W-1:0]   rd_q;

  mc_regfile #(.WR_W(WR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cfg_o(cfg), .check_o(check_val),
    .len_load_o(len_load), .cfg_err_o(cfg_err),
    .test_o(test_pulse), .sts_clr_o(sts_clr)
  );

  assign reload_en = cfg.reload;
  assign ie        = cfg.ie;

  mc_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk_i(clk_i), .rst_i(rst_i),
    .load_i(len_load), .load_val_i(wr_data_i[LEN_W-1:0]),
    .in_wr_i(in_wr_i), .reload_en_i(reload_en),
    .len_o(len_live), .rld_o(len_rld),
    .eom_o(eom), .len_err_o(len_err)
  );

  // comparison one cycle after the final write, once the kernel result settled
  assign consume = eom && cfg.chk_en;
  assign mis_evt = consume && ((crc_res_i != check_val) || force_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) force_q <= 1'b0;
    else       force_q <= (force_q && !consume) || test_pulse[0];
  end

  assign sts_set = {bus_err_i, len_err, cfg_err | test_pulse[1] | test_pulse[2], mis_evt};

  mc_status u_sts (
    .clk_i(clk_i), .rst_i(rst_i),
    .set_i(sts_set), .clr_i(sts_clr), .ie_i(ie),
    .flags_o(flags), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else begin
      case (rd_addr_i)
        A_CFG:   rd_q <= WR_W'(cfg);
        A_LEN:   rd_q <= WR_W'(len_live);
        A_CHK:   rd_q <= WR_W'(check_val);
        A_STS:   rd_q <= WR_W'(flags);
        A_RLD:   rd_q <= WR_W'(len_rld);
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign len_o     = len_live;
  assign status_o  = flags;
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic             in_wr_i,
  input logic             bus_err_i,
  input logic [LEN_W-1:0] len_o,
  input logic [3:0]       status_o,
  input logic             irq_o,
  input logic [3:0]       ie,
  input logic             reload_en,
  input logic             len_load,
  input logic             cfg_err
);
  // R9
  flags_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_en_i && wr_addr_i == 3'd3) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R10
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (irq_o == |($past(status_o) & $past(ie))));

  // R4
  len_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_wr_i && len_o > LEN_W'(1) && !len_load) |=> (len_o == LEN_W'($past(len_o) - 1'b1)));

  // R7
  len_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_wr_i && len_o == '0 && !reload_en && !len_load) |=> (status_o[2] && len_o == '0));

  // R8
  bus_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_err_i |=> status_o[3]);

  // R3
  cfg_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_err |=> status_o[1]);
endmodule

bind msg_len_check mc_checker #(.LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .in_wr_i(in_wr_i), .bus_err_i(bus_err_i), .len_o(len_o), .status_o(status_o),
  .irq_o(irq_o), .ie(ie), .reload_en(reload_en), .len_load(len_load), .cfg_err(cfg_err)
);

// File: tb/msg_len_check_bench.sv
`timescale 1ns/1ps
module msg_len_check_bench;
  localparam logic [31:0] KEY = 32'hFACECAFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        in_wr = 1'b0;
  logic [31:0] crc_res = '0;
  logic        bus_err = 1'b0;
  logic [15:0] len;
  logic [3:0]  status;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  msg_len_check u_msg_len_check (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .in_wr_i(in_wr), .crc_res_i(crc_res),
    .bus_err_i(bus_err), .len_o(len), .status_o(status), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [5:0]  m_cfg;
  logic [31:0] m_chk, m_rd;
  logic [15:0] m_len, m_rld;
  logic        m_eom, m_force, m_irq, m_uv;
  logic [2:0]  m_ua;
  logic [3:0]  m_sts;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = '0; m_chk = '0; m_rd = '0; m_len = '0; m_rld = '0;
      m_eom = 0; m_force = 0; m_irq = 0; m_uv = 0; m_ua = '0; m_sts = '0;
    end else begin
      logic [5:0]  cfg_n;
      logic [31:0] chk_n, rd_n;
      logic [15:0] len_n, rld_n;
      logic        eom_n, force_n, uv_n, cfgerr, lenerr, mis, checked;
      logic [2:0]  ua_n, tst;
      logic [3:0]  clr, set;
      cfg_n = m_cfg; chk_n = m_chk; len_n = m_len; rld_n = m_rld;
      uv_n = m_uv; ua_n = m_ua; eom_n = 0; cfgerr = 0; lenerr = 0;
      checked = m_eom && m_cfg[0];
      mis = checked && ((crc_res != m_chk) || m_force);
      tst = (wr_en && wr_addr == 3'd4) ? wr_data[2:0] : 3'b000;
      clr = (wr_en && wr_addr == 3'd3) ? wr_data[3:0] : 4'b0000;
      force_n = (m_force && !checked) || tst[0];
      if (wr_en) begin
        uv_n = 0;
        if (wr_addr == 3'd0) cfg_n = wr_data[5:0];
        if (wr_addr == 3'd1 || wr_addr == 3'd2) begin
          if (m_uv && m_ua == wr_addr) begin
            if (wr_addr == 3'd1) begin len_n = wr_data[15:0]; rld_n = wr_data[15:0]; end
            else chk_n = wr_data;
          end else if (wr_data == KEY) begin
            uv_n = 1; ua_n = wr_addr;
          end else cfgerr = 1;
        end
      end
      if (!(wr_en && wr_addr == 3'd1 && m_uv && m_ua == 3'd1) && in_wr) begin
        if (m_len == 0) lenerr = !m_cfg[1];
        else if (m_len == 1) begin eom_n = 1; len_n = m_cfg[1] ? m_rld : 16'd0; end
        else len_n = m_len - 16'd1;
      end
      set = {bus_err, lenerr, cfgerr | tst[1] | tst[2], mis};
      case (rd_addr)
        3'd0: rd_n = {26'd0, m_cfg};
        3'd1: rd_n = {16'd0, m_len};
        3'd2: rd_n = m_chk;
        3'd3: rd_n = {28'd0, m_sts};
        3'd5: rd_n = {16'd0, m_rld};
        default: rd_n = '0;
      endcase
      m_irq = |(m_sts & m_cfg[5:2]);
      m_sts = (m_sts & ~clr) | set;
      m_cfg = cfg_n; m_chk = chk_n; m_len = len_n; m_rld = rld_n;
      m_eom = eom_n; m_force = force_n; m_uv = uv_n; m_ua = ua_n; m_rd = rd_n;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("model status (R9)", {28'd0, status}, {28'd0, m_sts});
      check("model length (R4)", {16'd0, len}, {16'd0, m_len});
      check("model irq (R10)", {31'd0, irq}, {31'd0, m_irq});
      check("model read (R12)", rd_data, m_rd);
    end
  end

  // ---------------- stimulus tasks, entered at a negedge ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic keyed(input logic [2:0] a, input logic [31:0] d);
    wr(a, KEY);
    wr(a, d);
  endtask

  task automatic in_w();
    in_wr = 1;
    @(negedge clk);
    in_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_pulse();
    bus_err = 1;
    @(negedge clk);
    bus_err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    // R1 reset state
    check("R1 status", {28'd0, status}, 32'd0);
    check("R1 length", {16'd0, len}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 read", rd_data, 32'd0);

    wr(3'd0, 32'h3D);
    wr(3'd1, 32'd5);                       // no key
    check("R3 cfg error flag", {28'd0, status}, 32'h2);
    check("R3 length unchanged", {16'd0, len}, 32'd0);
    idle(1);
    check("R10 irq after enabled flag", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'h2);
    check("R9 write-one clear", {28'd0, status}, 32'd0);

    keyed(3'd1, 32'd3);
    check("R2 keyed length load", {16'd0, len}, 32'd3);
    rd_addr = 3'd5;
    idle(1);
    check("R12 reload copy readback", rd_data, 32'd3);

    keyed(3'd2, 32'h1234);
    crc_res = 32'h1234;
    in_w();
    check("R4 decrement", {16'd0, len}, 32'd2);
    in_w(); in_w();
    check("R4 reaches zero", {16'd0, len}, 32'd0);
    idle(1);
    check("R5 matching result no flag", {28'd0, status}, 32'd0);

    crc_res = 32'hBEEF;
    keyed(3'd1, 32'd2);
    in_w(); in_w();
    idle(1);
    check("R5 mismatch flag", {28'd0, status}, 32'h1);
    idle(1);
    check("R10 irq on mismatch", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'h1);

    in_w();
    check("R7 length error", {28'd0, status}, 32'h4);
    check("R7 length stays zero", {16'd0, len}, 32'd0);
    wr(3'd3, 32'h4);

    crc_res = 32'h1234;
    wr(3'd0, 32'h3F);
    keyed(3'd1, 32'd2);
    in_w(); in_w();
    check("R6 reload restores length", {16'd0, len}, 32'd2);
    idle(1);
    check("R6 no error on reload", {28'd0, status}, 32'd0);

    bus_pulse();
    check("R8 bus error flag", {28'd0, status}, 32'h8);
    idle(3);
    check("R9 flag sticky", {28'd0, status}, 32'h8);
    wr_en = 1; wr_addr = 3'd3; wr_data = 32'h8; bus_err = 1;
    @(negedge clk);
    wr_en = 0; bus_err = 0;
    check("R9 set wins over clear", {28'd0, status}, 32'h8);
    wr(3'd3, 32'h8);
    check("R9 cleared", {28'd0, status}, 32'd0);

    wr(3'd4, 32'h1);
    in_w(); in_w();
    idle(1);
    check("R11 forced mismatch", {28'd0, status}, 32'h1);
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h2);
    check("R11 forced config fault", {28'd0, status}, 32'h2);
    wr(3'd3, 32'h2);
    wr(3'd4, 32'h4);
    check("R11 forced check-register fault", {28'd0, status}, 32'h2);
    wr(3'd3, 32'h2);

    wr(3'd2, KEY);
    wr(3'd0, 32'h3F);                      // breaks the unlock
    wr(3'd2, 32'h55);
    check("R3 broken unlock rejected", {28'd0, status}, 32'h2);
    rd_addr = 3'd2;
    idle(1);
    check("R2 check value unchanged", rd_data, 32'h1234);
    wr(3'd3, 32'h2);

    wr(3'd0, 32'h03);
    bus_pulse();
    idle(2);
    check("R10 masked flag no irq", {31'd0, irq}, 32'd0);
    check("R8 flag set while masked", {28'd0, status}, 32'h8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule